// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps return addresses for a small processor core. A call or explicit push saves the current program counter into an internal array. A return or explicit pop discards the top entry. A 5-bit pointer selects the current top. Pointer value 0 means the stack is empty, and slots 1 to 31 hold data.

Software reaches the block through a 2-bit byte register window. Address 0 is a status byte that holds two sticky error flags and the pointer. Addresses 1 to 3 are the low, middle and upper bytes of the top entry. Software can read these bytes, and it can overwrite them to plant data or a new return address.

A configuration input selects what an error does. An overflow or an underflow can raise only its flag, or it can also send a one-cycle reset request to the chip's reset logic.

Top module: `rstack_top`

## Requirements
- R1: A push raises the pointer by one and stores `pushPc` in the newly addressed slot. From the next cycle the top-of-stack bytes read that value.
- R2: A pop on a non-empty stack lowers the pointer by one. It does not modify any slot, so the value pushed before becomes the top again.
- R3: Register addresses 1, 2 and 3 read and write bits 7:0, 15:8 and 20:16 of the top entry. Address 3 reads its bits 7:5 as 0, and writes ignore those bits.
- R4: Register address 0 reads {full flag, underflow flag, 0, pointer[4:0]}, with the full flag in bit 7 and the underflow flag in bit 6.
- R5: The full flag sets on a push that brings the pointer to 31. A push while the pointer is 31 sets the flag again and changes neither the pointer nor slot 31.
- R6: The two flags are sticky. A register write to address 0 clears a flag whose data bit is 0 and leaves a flag whose data bit is 1 unchanged. Such a write can never set a flag.
- R7: A register write to address 0 loads data bits 4:0 into the pointer. The slot contents are kept.
- R8: With `resetOnErr` at 0, an overflow or underflow raises no reset request. With `resetOnErr` at 1, `resetReq` is high for exactly the one cycle after the event.
- R9: A pop with the pointer at 0 sets the underflow flag and leaves the pointer at 0. The top-of-stack bytes read 0 whenever the pointer is 0.
- R10: A push and a pop in the same cycle act as a push alone. A register write in the same cycle as a push or a pop is ignored.
- R11: After reset the status byte, the top-of-stack bytes and `resetReq` are all 0.
- R12: A write to a top-of-stack byte while the pointer is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| pushReq | input | 1 | Call or push strobe |
| pushPc | input | 21 | Program counter to be saved |
| popReq | input | 1 | Return or pop strobe |
| regAddr | input | 2 | Register select: 0 status, 1 low, 2 middle, 3 upper |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read of the selected register |
| tosValue | output | 21 | Current top entry, 0 when empty |
| resetOnErr | input | 1 | 1: stack errors request a device reset |
| resetReq | output | 1 | One-cycle reset request |

## Verification
Several behaviours are checked by the assertions on every cycle:
- the pointer moves by exactly one on a push or a pop;
- the pointer stays at 0 on an underflow and at 31 on an overflow;
- a software write loads the pointer;
- the flags stay set until a clearing write;
- `resetReq` never rises while the reset option is off;
- the top entry reads 0 when the stack is empty.

Other behaviours need the bench's scenarios, because they depend on the data in the slots:
- that slot contents survive pops and pointer rewrites;
- that slot 31 is kept on overflow;
- that the byte lanes and the masking of the upper byte are correct;
- how simultaneous operations are ordered.

// File: rtl/rstack_pkg.sv
package rstack_pkg;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_TOS_LO = 2'd1,
    REG_TOS_HI = 2'd2,
    REG_TOS_UP = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       pushWr;   // store pushPc at pointer + 1
    logic       tosWr;    // merge one byte into the current top slot
    logic [1:0] tosLane;  // which byte lane tosWr targets
  } dpStrobe_t;

endpackage

// File: rtl/rstack_ctrl.sv
module rstack_ctrl
  import rstack_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  logic             resetOnErr,
  output logic [PTR_W-1:0] stackPtr,
  output logic             fullFlag,
  output logic             unfFlag,
  output logic             resetReq,
  output dpStrobe_t        strobe
);

  localparam logic [PTR_W-1:0] PTR_MAX  = '1;
  localparam logic [PTR_W-1:0] PTR_NEAR = {{(PTR_W-1){1'b1}}, 1'b0};

  logic isEmpty, isFull;
  logic doPush, doPop, swWr, swStatus;
  logic fullEvent, unfEvent;
  logic [PTR_W-1:0] ptrNext;
  logic fullNext, unfNext;

  assign isEmpty  = (stackPtr == '0);
  assign isFull   = (stackPtr == PTR_MAX);

  // push wins over pop; register writes yield to both
  assign doPush   = pushReq;
  assign doPop    = popReq && !pushReq;
  assign swWr     = regWrEn && !pushReq && !popReq;
  assign swStatus = swWr && (regAddr == REG_STATUS);

  assign fullEvent = doPush && (stackPtr >= PTR_NEAR);
  assign unfEvent  = doPop && isEmpty;

  always_comb begin
    ptrNext = stackPtr;
    if (doPush && !isFull)       ptrNext = stackPtr + 1'b1;
    else if (doPop && !isEmpty)  ptrNext = stackPtr - 1'b1;
    else if (swStatus)           ptrNext = regWrData[PTR_W-1:0];
  end

  always_comb begin
    fullNext = fullFlag;
    unfNext  = unfFlag;
    if (fullEvent) fullNext = 1'b1;
    if (unfEvent)  unfNext  = 1'b1;
    if (swStatus && !regWrData[7]) fullNext = 1'b0;
    if (swStatus && !regWrData[6]) unfNext  = 1'b0;
  end

  always_comb begin
    strobe.pushWr  = doPush && !isFull;
    strobe.tosWr   = swWr && (regAddr != REG_STATUS) && !isEmpty;
    strobe.tosLane = regAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr <= '0;
      fullFlag <= 1'b0;
      unfFlag  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      stackPtr <= ptrNext;
      fullFlag <= fullNext;
      unfFlag  <= unfNext;
      resetReq <= resetOnErr && (fullEvent || unfEvent);
    end
  end

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !isFull |=> stackPtr == $past(stackPtr) + 1'b1); // R1
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rstN)
    popReq && !pushReq && !isEmpty |=> stackPtr == $past(stackPtr) - 1'b1); // R2
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && stackPtr >= PTR_NEAR |=> fullFlag && stackPtr == PTR_MAX); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag && !(swStatus && !regWrData[7]) |=> fullFlag); // R6
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag && !(swStatus && !regWrData[6]) |=> unfFlag); // R6
  AST_PTR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    swStatus |=> stackPtr == $past(regWrData[PTR_W-1:0])); // R7
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    popReq && !pushReq && isEmpty |=> unfFlag && stackPtr == '0); // R9

endmodule

// File: rtl/rstack_dp.sv
module rstack_dp
  import rstack_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PTR_W-1:0] stackPtr,
  input  logic [PC_W-1:0]  pushPc,
  input  logic [7:0]       regWrData,
  output logic [PC_W-1:0]  tosValue
);

  localparam int SLOTS = 1 << PTR_W;
  localparam int UP_W  = PC_W - 16;

  logic [PC_W-1:0]  slotQ [SLOTS];
  logic [PC_W-1:0]  laneMerge;
  logic [PTR_W-1:0] pushIdx;

  assign pushIdx  = stackPtr + 1'b1;
  assign tosValue = slotQ[stackPtr];

  always_comb begin
    laneMerge = tosValue;
    case (strobe.tosLane)
      2'd1:    laneMerge[7:0]       = regWrData;
      2'd2:    laneMerge[15:8]      = regWrData;
      2'd3:    laneMerge[PC_W-1:16] = regWrData[UP_W-1:0];
      default: laneMerge = tosValue;
    endcase
  end

  // slot 0 is never selected (push never targets it, top writes are
  // blocked when empty), so it keeps its reset value of zero
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic selPush, selTos;
    assign selPush = strobe.pushWr && (pushIdx == PTR_W'(g));
    assign selTos  = strobe.tosWr && (stackPtr == PTR_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        slotQ[g] <= '0;
      else if (selPush) slotQ[g] <= pushPc;
      else if (selTos)  slotQ[g] <= laneMerge;
    end
  end

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stackPtr == '0 |-> tosValue == '0); // R9
  AST_PUSH_STORE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushWr |=> tosValue == $past(pushPc)); // R1

endmodule

// File: rtl/rstack_top.sv
module rstack_top
  import rstack_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int PTR_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pushReq,
  input  logic [PC_W-1:0] pushPc,
  input  logic            popReq,
  input  logic [1:0]      regAddr,
  input  logic            regWrEn,
  input  logic [7:0]      regWrData,
  output logic [7:0]      regRdData,
  output logic [PC_W-1:0] tosValue,
  input  logic            resetOnErr,
  output logic            resetReq
);

  localparam int UP_W = PC_W - 16;

  dpStrobe_t        strobe;
  logic [PTR_W-1:0] stackPtr;
  logic             fullFlag, unfFlag;
  logic [7:0]       statusByte;

  rstack_ctrl #(.PTR_W(PTR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .resetOnErr(resetOnErr), .stackPtr(stackPtr), .fullFlag(fullFlag),
    .unfFlag(unfFlag), .resetReq(resetReq), .strobe(strobe)
  );

  rstack_dp #(.PC_W(PC_W), .PTR_W(PTR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stackPtr(stackPtr),
    .pushPc(pushPc), .regWrData(regWrData), .tosValue(tosValue)
  );

  assign statusByte = {fullFlag, unfFlag, {(6-PTR_W){1'b0}}, stackPtr};

  always_comb begin
    case (regAddr)
      REG_STATUS: regRdData = statusByte;
      REG_TOS_LO: regRdData = tosValue[7:0];
      REG_TOS_HI: regRdData = tosValue[15:8];
      default:    regRdData = {{(8-UP_W){1'b0}}, tosValue[PC_W-1:16]};
    endcase
  end

  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(resetOnErr)); // R8
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq || $past(pushReq || popReq)); // R8

endmodule

// File: tb/test_rstack_top.sv
`timescale 1ns/100ps
module test_rstack_top;

  typedef struct {
    int         kind;   // 0..3 register address, 4 = resetReq port
    logic [7:0] val;
    string      tag;
  } item_t;

  logic        clk = 0, rstN = 0;
  logic        pushReq = 0, popReq = 0, regWrEn = 0, resetOnErr = 0;
  logic [20:0] pushPc = '0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [20:0] tosValue;
  logic        resetReq;

  int checks = 0, failures = 0;
  bit done = 0;
  item_t q[$];

  always #5 clk = ~clk;

  rstack_top i_rstack_top (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .pushPc(pushPc),
    .popReq(popReq), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .tosValue(tosValue),
    .resetOnErr(resetOnErr), .resetReq(resetReq)
  );

  function automatic logic [20:0] pcOf(input int i);
    return 21'((i * 4099 + 17) & 'h1FFFFF);
  endfunction

  task automatic expectItem(input int kind, input logic [7:0] val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(input logic push, input logic [20:0] pc, input logic pop,
                      input logic wr, input logic [1:0] addr, input logic [7:0] wd);
    @(negedge clk); #3;
    pushReq = push; pushPc = pc; popReq = pop;
    regWrEn = wr; regAddr = addr; regWrData = wd;
    @(posedge clk); #1;
    pushReq = 0; popReq = 0; regWrEn = 0;
  endtask

  // monitor: compares queued expectations at the negedge after the operation
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        if (it.kind < 4) begin
          regAddr = it.kind[1:0];
          #0.2;
          act = regRdData;
        end else begin
          #0.2;
          act = {7'd0, resetReq};
        end
        checks++;
        if (act !== it.val) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R11 reset state, R4 status layout
    expectItem(0, 8'h00, "R11/R4 status");
    expectItem(1, 8'h00, "R11 tos lo");
    expectItem(3, 8'h00, "R11 tos up");
    expectItem(4, 8'h00, "R11 resetReq");

    step(1, 21'h1ABCDE, 0, 0, 0, 0);               // R1
    expectItem(0, 8'h01, "R1 ptr");
    expectItem(3, 8'h1A, "R1 up");
    expectItem(2, 8'hBC, "R1 hi");
    expectItem(1, 8'hDE, "R1 lo");

    step(1, 21'h012345, 0, 0, 0, 0);
    expectItem(0, 8'h02, "R1 ptr2");
    expectItem(1, 8'h45, "R1 lo2");
    expectItem(3, 8'h01, "R1 up2");

    step(0, '0, 1, 0, 0, 0);                         // R2
    expectItem(0, 8'h01, "R2 ptr");
    expectItem(1, 8'hDE, "R2 lo");
    expectItem(2, 8'hBC, "R2 hi");

    step(0, '0, 0, 1, 2'd1, 8'h77);                  // R3
    expectItem(1, 8'h77, "R3 lo write");
    step(0, '0, 0, 1, 2'd2, 8'h66);
    expectItem(2, 8'h66, "R3 hi write");
    step(0, '0, 0, 1, 2'd3, 8'hFF);
    expectItem(3, 8'h1F, "R3 up masked");
    expectItem(1, 8'h77, "R3 lo kept");

    step(0, '0, 1, 0, 0, 0);
    expectItem(0, 8'h00, "R9 empty ptr");
    expectItem(1, 8'h00, "R9 empty tos");

    step(0, '0, 1, 0, 0, 0);                         // underflow, option off
    expectItem(0, 8'h40, "R9 underflow");
    expectItem(1, 8'h00, "R9 tos zero");
    expectItem(4, 8'h00, "R8 no request");

    step(0, '0, 0, 1, 2'd1, 8'h55);                  // R12
    expectItem(1, 8'h00, "R12 write ignored");

    step(0, '0, 0, 1, 2'd0, 8'hFF);                  // R6, R7
    expectItem(0, 8'h5F, "R6/R7 write ones");
    step(0, '0, 0, 1, 2'd0, 8'h00);
    expectItem(0, 8'h00, "R6 clear");

    resetOnErr = 1;
    step(0, '0, 1, 0, 0, 0);
    expectItem(0, 8'h40, "R8 underflow flag");
    expectItem(4, 8'h01, "R8 request");
    step(0, '0, 0, 0, 0, 0);
    expectItem(4, 8'h00, "R8 one cycle");

    step(0, '0, 0, 1, 2'd0, 8'h00);
    expectItem(0, 8'h00, "R6 clear2");

    for (int i = 1; i <= 31; i++) begin
      step(1, pcOf(i), 0, 0, 0, 0);
      if (i == 30) expectItem(0, 8'h1E, "R5 not yet full");
    end
    expectItem(0, 8'h9F, "R5 full");
    expectItem(4, 8'h01, "R8 full request");
    expectItem(1, pcOf(31) & 21'hFF, "R5 slot31");

    resetOnErr = 0;
    step(1, 21'h0AAAAA, 0, 0, 0, 0);                  // overflow
    expectItem(0, 8'h9F, "R5 overflow ptr");
    expectItem(1, pcOf(31) & 21'hFF, "R5 slot31 kept");
    expectItem(2, (pcOf(31) >> 8) & 21'hFF, "R5 slot31 hi kept");
    expectItem(4, 8'h00, "R8 overflow no request");

    step(0, '0, 0, 1, 2'd0, 8'h5F);
    expectItem(0, 8'h1F, "R6 full cleared");

    step(0, '0, 0, 1, 2'd0, 8'h05);
    expectItem(0, 8'h05, "R7 ptr load");
    expectItem(1, pcOf(5) & 21'hFF, "R7 slot kept");

    step(1, 21'h155555, 1, 0, 0, 0);                  // R10
    expectItem(0, 8'h06, "R10 push wins");
    expectItem(1, 8'h55, "R10 push data");
    expectItem(3, 8'h15, "R10 push up");

    step(0, '0, 1, 1, 2'd0, 8'h00);
    expectItem(0, 8'h05, "R10 write ignored");
    expectItem(1, pcOf(5) & 21'hFF, "R10 tos");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule